// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the event status, the interrupt enables and the run state for a group of DMA channels, and drives one level-sensitive interrupt line per channel. Each channel's transfer engine signals four kinds of event by single-cycle pulses: timeout, dropped synchronisation event, frame done and block done. Each pulse sets a sticky flag in that channel's status word.

Software reaches three words per channel over a simple register port: a control word, an interrupt-enable word and the status word. The port has a request strobe, a write flag, a word select and a channel index. Read data is combinational in the request cycle. A read of the status word returns the flags gathered so far and empties them at the same clock edge. A channel's interrupt line is high while any flag that is both set and enabled remains.

Each channel also has an active flag. Software sets it by starting the channel through the control word. It drops when the channel is stopped or when its engine reports block done.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every status word, enable word and control word reads 0, and every bit of irq_o and active_o is 0.
- R2: An event pulse sets its status bit at the next clock edge: timeout sets bit 0, drop sets bit 1, frame sets bit 3 and block sets bit 5. Set bits stay set until the status word is read.
- R3: Status bits 2, 4 and 6 to 15 always read 0. Only bits 0, 1, 3 and 5 of a written enable word are kept (written 0xFFFF reads back 0x002B).
- R4: A status read (reg_sel_i = 2, reg_wr_i = 0) returns the gathered flags and clears them at that clock edge, so a second read returns 0.
- R5: An event pulse in the same cycle as a clearing status read is not lost. That read returns the older flags, and the new bit is set after the edge.
- R6: irq_o for a channel is high exactly while its status AND its enable word is non-zero. An enable word of 0 keeps the line low. Enabling a flag that is already pending raises the line one edge after the write.
- R7: A control write (reg_sel_i = 0) with bit 7 set turns the channel on and sets its active flag. A control read returns the channel-on state in bit 7, with all other bits 0.
- R8: A block-done pulse clears the active flag and leaves control bit 7 set. If a control write with bit 7 set happens in the same cycle, the active flag stays set.
- R9: A control write with bit 7 clear turns the channel off and clears its active flag.
- R10: A write to the status word has no effect. An access to one channel leaves every other channel's words and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | Word select: 0 control, 1 enable, 2 status, 3 unused (reads 0) |
| reg_ch_i | input | CH_W | Channel index |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the request cycle |
| ev_timeout_i | input | NUM_CH | Timeout event pulses |
| ev_drop_i | input | NUM_CH | Dropped synchronisation event pulses |
| ev_frame_i | input | NUM_CH | Frame done pulses |
| ev_block_i | input | NUM_CH | Block done pulses |
| irq_o | output | NUM_CH | Per-channel interrupt lines, level |
| active_o | output | NUM_CH | Per-channel active flags |

## Verification
The bench aims at the cycle where a clearing read meets a new event. A design that applies the clear after the capture drops the frame flag, and the bench's second read sees 0 instead of 0x0008. The bench also starts a channel in the same cycle that block done arrives, so a design that gives block done priority shows active low. It enables a flag that is already pending, and writes 0xFFFF to the enable and status words. Wrong masking then shows as reserved bits in read data, a missing interrupt, or status that a write has changed.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W     = 16;
  localparam int BIT_TOUT  = 0;
  localparam int BIT_DROP  = 1;
  localparam int BIT_FRAME = 3;
  localparam int BIT_BLOCK = 5;
  localparam int BIT_RUN   = 7;
  localparam logic [REG_W-1:0] EVT_MASK = (REG_W'(1) << BIT_TOUT) | (REG_W'(1) << BIT_DROP) |
                                          (REG_W'(1) << BIT_FRAME) | (REG_W'(1) << BIT_BLOCK);
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [NUM_CH-1:0] ctrl_we_o,
  output logic [NUM_CH-1:0] ien_we_o,
  output logic [NUM_CH-1:0] stat_rd_o
);
  import dma_irq_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic hit;
    assign hit          = req_i && (ch_i == CH_W'(c));
    assign ctrl_we_o[c] = hit && wr_i  && (sel_i == SEL_CTRL);
    assign ien_we_o[c]  = hit && wr_i  && (sel_i == SEL_IEN);
    assign stat_rd_o[c] = hit && !wr_i && (sel_i == SEL_STAT);
  end

  always_comb begin
    if (req_i) assert ($countones(ctrl_we_o | ien_we_o | stat_rd_o) <= 1)
      else $error("p_one_strobe_r10");
  end
endmodule

// File: rtl/dma_ch_status.sv
module dma_ch_status
  import dma_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ien_we_i,
  input  logic             stat_rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ev_timeout_i,
  input  logic             ev_drop_i,
  input  logic             ev_frame_i,
  input  logic             ev_block_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] ien_o,
  output logic [REG_W-1:0] stat_o,
  output logic             irq_o,
  output logic             active_o
);
  logic [REG_W-1:0] stat_q, ien_q, ev_vec;
  logic             run_q, act_q;

  always_comb begin
    ev_vec            = '0;
    ev_vec[BIT_TOUT]  = ev_timeout_i;
    ev_vec[BIT_DROP]  = ev_drop_i;
    ev_vec[BIT_FRAME] = ev_frame_i;
    ev_vec[BIT_BLOCK] = ev_block_i;
  end

  // clear-on-read, but same-cycle events survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_rd_i ? '0 : stat_q) | ev_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ien_we_i) ien_q <= wdata_i & EVT_MASK;
  end

  // software start outranks block-done in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
    end else if (ctrl_we_i) begin
      run_q <= wdata_i[BIT_RUN];
      act_q <= wdata_i[BIT_RUN];
    end else if (ev_block_i) begin
      act_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[BIT_RUN] = run_q;
  end
  assign ien_o    = ien_q;
  assign stat_o   = stat_q;
  assign irq_o    = |(stat_q & ien_q);
  assign active_o = act_q;

  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ev_timeout_i && !ev_drop_i && !ev_frame_i && !ev_block_i) |=> (stat_o == '0));
  p_event_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_frame_i |=> stat_o[BIT_FRAME]);
  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~EVT_MASK) == '0);
  p_block_drops_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_block_i && !ctrl_we_i) |=> !active_o);
  p_stop_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[BIT_RUN]) |=> (!active_o && ctrl_o == '0));
  p_no_irq_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_we_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [CH_W-1:0]   reg_ch_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] ev_timeout_i,
  input  logic [NUM_CH-1:0] ev_drop_i,
  input  logic [NUM_CH-1:0] ev_frame_i,
  input  logic [NUM_CH-1:0] ev_block_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] active_o
);
  logic [NUM_CH-1:0] ctrl_we, ien_we, stat_rd;
  logic [REG_W-1:0]  ctrl_w [NUM_CH];
  logic [REG_W-1:0]  ien_w  [NUM_CH];
  logic [REG_W-1:0]  stat_w [NUM_CH];

  dma_reg_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .req_i     (reg_req_i),
    .wr_i      (reg_wr_i),
    .sel_i     (reg_sel_i),
    .ch_i      (reg_ch_i),
    .ctrl_we_o (ctrl_we),
    .ien_we_o  (ien_we),
    .stat_rd_o (stat_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_ch_status u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_we_i    (ctrl_we[c]),
      .ien_we_i     (ien_we[c]),
      .stat_rd_i    (stat_rd[c]),
      .wdata_i      (reg_wdata_i),
      .ev_timeout_i (ev_timeout_i[c]),
      .ev_drop_i    (ev_drop_i[c]),
      .ev_frame_i   (ev_frame_i[c]),
      .ev_block_i   (ev_block_i[c]),
      .ctrl_o       (ctrl_w[c]),
      .ien_o        (ien_w[c]),
      .stat_o       (stat_w[c]),
      .irq_o        (irq_o[c]),
      .active_o     (active_o[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_req_i && !reg_wr_i && reg_ch_i == CH_W'(c)) begin
        unique case (reg_sel_i)
          SEL_CTRL: reg_rdata_o = ctrl_w[c];
          SEL_IEN:  reg_rdata_o = ien_w[c];
          SEL_STAT: reg_rdata_o = stat_w[c];
          default:  reg_rdata_o = '0;
        endcase
      end
    end
  end

  p_idle_rdata_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |-> (reg_rdata_o == '0));
endmodule

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_req = 1'b0, reg_wr = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic [CH_W-1:0]   reg_ch = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic [NUM_CH-1:0] ev_t = '0, ev_d = '0, ev_f = '0, ev_b = '0;
  logic [NUM_CH-1:0] irq, active;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dma_irq_status #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(reg_req), .reg_wr_i(reg_wr),
    .reg_sel_i(reg_sel), .reg_ch_i(reg_ch), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ev_timeout_i(ev_t), .ev_drop_i(ev_d),
    .ev_frame_i(ev_f), .ev_block_i(ev_b), .irq_o(irq), .active_o(active)
  );

  // monitor: compare each read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && reg_req && !reg_wr) begin
      logic [15:0] e; string t;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++; $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++; $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_req = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    ev_t = 0; ev_d = 0; ev_f = 0; ev_b = 0;
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [15:0] d);
    step();
    reg_req = 1; reg_wr = 1; reg_ch = CH_W'(ch); reg_sel = sel; reg_wdata = d;
  endtask

  task automatic rd(input int ch, input logic [1:0] sel, input logic [15:0] e, input string t);
    step();
    reg_req = 1; reg_wr = 0; reg_ch = CH_W'(ch); reg_sel = sel;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic chk(input logic [NUM_CH-1:0] a, input logic [NUM_CH-1:0] e, input string t);
    @(negedge clk);
    n_cmp++;
    if (a !== e) begin
      n_bad++; $display("FAIL %s: actual %b expected %b", t, a, e);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    chk(irq, '0, "R1 irq after reset");
    chk(active, '0, "R1 active after reset");
    rd(0, 2, 16'h0000, "R1 status reset");
    rd(0, 1, 16'h0000, "R1 enable reset");
    rd(0, 0, 16'h0000, "R1 control reset");

    // R2 single event, R4 clear-on-read
    step(); ev_t[0] = 1;
    rd(0, 2, 16'h0001, "R2 timeout bit0");
    rd(0, 2, 16'h0000, "R4 second read empty");

    // R2/R3 all events accumulate, reserved zero
    step(); ev_t[1] = 1; ev_d[1] = 1;
    step(); ev_f[1] = 1; ev_b[1] = 1;
    rd(1, 2, 16'h002B, "R2 R3 accumulated flags");

    // R3 enable masking
    wr(2, 1, 16'hFFFF);
    rd(2, 1, 16'h002B, "R3 enable mask");

    // R6 irq follows status & enable
    step(); ev_d[2] = 1;
    step();
    chk(irq, 4'b0100, "R6 irq raised");
    rd(2, 2, 16'h0002, "R6 drop status");
    step();
    chk(irq, 4'b0000, "R6 irq cleared by read");

    // R6 enable 0 suppresses; later enable raises
    step(); ev_t[3] = 1;
    step();
    chk(irq, 4'b0000, "R6 masked when enable 0");
    wr(3, 1, 16'h0001);
    step();
    chk(irq, 4'b1000, "R6 enable pending flag");
    rd(3, 2, 16'h0001, "R6 status ch3");
    step();
    chk(irq, 4'b0000, "R6 irq low after read");

    // R5 event during clearing read
    rd(0, 2, 16'h0000, "R5 read with event");
    ev_f[0] = 1;
    rd(0, 2, 16'h0008, "R5 event kept");

    // R7 start
    wr(1, 0, 16'h0080);
    step();
    chk(active, 4'b0010, "R7 active set");
    rd(1, 0, 16'h0080, "R7 control readback");
    // R8 block done
    step(); ev_b[1] = 1;
    step();
    chk(active, 4'b0000, "R8 block clears active");
    rd(1, 0, 16'h0080, "R8 run bit kept");
    rd(1, 2, 16'h0020, "R8 block status");
    // R8 start same cycle as block
    wr(1, 0, 16'h0080);
    ev_b[1] = 1;
    step();
    chk(active, 4'b0010, "R8 start wins over block");
    rd(1, 2, 16'h0020, "R8 block status again");

    // R9 stop
    wr(1, 0, 16'h0000);
    step();
    chk(active, 4'b0000, "R9 stop clears active");
    rd(1, 0, 16'h0000, "R9 control cleared");

    // R10 status write ignored, isolation
    wr(3, 0, 16'h0080);
    step(); ev_d[0] = 1;
    wr(0, 2, 16'hFFFF);
    rd(0, 2, 16'h0002, "R10 status write ignored");
    rd(2, 1, 16'h002B, "R10 other channel enable kept");
    step();
    chk(active, 4'b1000, "R10 other channel active kept");
    rd(3, 0, 16'h0080, "R10 ch3 control");
    step(); step();

    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule